// File: doc/BRIEF.md
# Interrupt priority sequencer

This block decides which pending interrupt request a small 8-bit CPU core serves next, and runs the fixed-length entry and return sequences around the handler. Each source is either latched or level-driven. A latched source records a one-cycle event pulse in a pending flag. A level source is pending only while its input is high. A source competes only when its own enable and the global enable are both set. The lowest source index wins. Vector 0 is kept for reset, so source `i` jumps to vector `i+1`.

A request is taken only at an instruction boundary when no multi-cycle instruction is still in flight, or at any cycle while the core is asleep. Taking a request clears the global enable, strobes a clear for the winner's flag, and starts an entry sequence. That sequence pushes the two-byte return address and lasts a fixed number of cycles. When the core was asleep, it lasts a fixed number of cycles longer. A return event starts a fixed-length return sequence. It pops both bytes and then sets the global enable again. Because the global enable is held in a register, the core always completes one instruction after SEI, or after a return, before any request can be taken. CLI blocks a take in its own cycle. All control pins are plain strobes and levels. No data stream crosses the block boundary, so there is no valid/ready handshake.

Top module: `irq_sequencer`

## Requirements
- R1: After reset `vec_o` is 0, which is the reset vector. Among enabled pending sources the lowest index wins, and source `i` is served at vector `i+1`.
- R2: A source is taken only when its `en_i` bit is set and `gie_o` is 1 in the deciding cycle.
- R3: `gie_o` resets to 0. It is cleared by a take and by `cli_i`. It is set by `sei_i` and by the last cycle of a return sequence.
- R4: For a latched source, `clr_o` pulses the winner's bit in the deciding cycle, and its pending flag is low from the next cycle. A one on `wclr_i` also clears a flag. An event arriving in the same cycle as a clear wins, and the flag stays set.
- R5: A latched flag that is set while its source is disabled stays pending and is served once it is enabled.
- R6: A level source is pending only while its input is high. It gets no clear strobe, and a pulse that ends before it is enabled is never served.
- R7: No take happens in the cycle of `sei_i`, nor before the first instruction boundary that follows a return sequence.
- R8: `cli_i` suppresses a take in the same cycle.
- R9: A take raises `take_o` for one cycle, in the cycle after the decision. `busy_o` is then high for ENTRY_CYC (4) cycles. `push_o` is high in the first two of those cycles, with `stk_hi_o` = 0 and then 1 (low byte first).
- R10: While `sleep_i` is high, a take needs no boundary. Such an entry adds WAKE_CYC (4) cycles before the two pushes, so `busy_o` lasts 8 cycles.
- R11: `reti_i` in an idle cycle starts RET_CYC (4) busy cycles. `pop_o` is high in the first two, with `stk_hi_o` = 1 and then 0, which moves the stack pointer up by two. `gie_o` is 1 afterwards.
- R12: No take happens while `mcb_i` is high, unless the core is asleep.
- R13: When several sources are pending at once, only the winner is cleared. The others stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| src_i | input | N_SRC | Event pulse (latched source) or live level (level source) |
| en_i | input | N_SRC | Per-source enable |
| wclr_i | input | N_SRC | Write-one-to-clear for latched flags |
| sei_i | input | 1 | Global-enable instruction completes |
| cli_i | input | 1 | Global-disable instruction, immediate |
| reti_i | input | 1 | Return-from-interrupt starts |
| bnd_i | input | 1 | An instruction completes this cycle |
| mcb_i | input | 1 | A multi-cycle instruction is still in flight |
| sleep_i | input | 1 | Core is asleep |
| take_o | output | 1 | First cycle of an entry sequence |
| vec_o | output | VEC_W | Vector of the last taken source |
| clr_o | output | N_SRC | Hardware clear strobe for the winner's flag |
| busy_o | output | 1 | Entry or return sequence in progress |
| push_o | output | 1 | Push one return-address byte |
| pop_o | output | 1 | Pop one return-address byte |
| stk_hi_o | output | 1 | Byte select for push/pop: 1 = high byte |
| gie_o | output | 1 | Global interrupt enable |
| pend_o | output | N_SRC | Pending state of each source |

## Verification
The bench raises SEI and a boundary together and checks that no clear strobe appears. A design that tested a combinational enable would enter one instruction too early. CLI is applied in the very cycle a boundary would take a request, which catches an enable that is only cleared a cycle late. A flag event and a write-one-clear are applied together: a design that gave the clear priority would lose a request. Three sources are made pending at once to show that only the lowest index is cleared. Entries from sleep and with a multi-cycle instruction in flight are checked cycle by cycle, so a wrong wake stretch or misplaced pushes show up as a mismatch on `busy_o`, `push_o` or `stk_hi_o`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_RET   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_SRC = 4,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] wclr_i,
  input  logic [N_SRC-1:0] hwclr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      // level sources keep no state: pending follows the pin
      assign pend_o[i] = src_i[i];
    end else begin : g_latch
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       flag_q <= 1'b0;
        else if (src_i[i])                 flag_q <= 1'b1;  // event beats clear
        else if (wclr_i[i] || hwclr_i[i])  flag_q <= 1'b0;
      end
      assign pend_o[i] = flag_q;

      assert_hwclr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hwclr_i[i] && !src_i[i]) |=> !pend_o[i]);
      assert_event_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_i[i] |=> pend_o[i]);
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [N_SRC-1:0] grant_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    // scan downward so the lowest requesting index is written last
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 4,
  parameter int unsigned WAKE_CYC  = 4,
  parameter int unsigned RET_CYC   = 4,
  parameter int unsigned VEC_W     = 3,
  parameter int unsigned IDX_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_now_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             sleep_i,
  input  logic             reti_i,
  input  logic             sei_i,
  input  logic             cli_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             busy_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             stk_hi_o,
  output logic             gie_o
);
  localparam int unsigned CNT_W = $clog2(ENTRY_CYC + WAKE_CYC + RET_CYC + 1);
  localparam logic [CNT_W-1:0] WAKE_C    = CNT_W'(WAKE_CYC);
  localparam logic [CNT_W-1:0] ENT_LAST  = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(ENTRY_CYC + WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] RET_LAST  = CNT_W'(RET_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wake_q;
  logic             gie_q;
  logic [VEC_W-1:0] vec_q;
  logic [CNT_W-1:0] push_off;
  logic [CNT_W-1:0] ent_last;
  logic             ret_done;

  assign push_off = wake_q ? WAKE_C : '0;
  assign ent_last = wake_q ? WAKE_LAST : ENT_LAST;
  assign ret_done = (state_q == ST_RET) && (cnt_q == RET_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wake_q  <= 1'b0;
      gie_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_now_i) begin
            state_q <= ST_ENTER;
            cnt_q   <= '0;
            wake_q  <= sleep_i;
            vec_q   <= VEC_W'(win_idx_i) + VEC_W'(1);
          end else if (reti_i) begin
            state_q <= ST_RET;
            cnt_q   <= '0;
          end
        end
        ST_ENTER: begin
          if (cnt_q == ent_last) state_q <= ST_IDLE;
          else                   cnt_q   <= cnt_q + CNT_W'(1);
        end
        ST_RET: begin
          if (ret_done) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q + CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase

      if (take_now_i || cli_i)    gie_q <= 1'b0;
      else if (sei_i || ret_done) gie_q <= 1'b1;
    end
  end

  assign take_o   = (state_q == ST_ENTER) && (cnt_q == '0);
  assign busy_o   = (state_q != ST_IDLE);
  assign push_o   = (state_q == ST_ENTER) &&
                    ((cnt_q == push_off) || (cnt_q == push_off + CNT_W'(1)));
  assign pop_o    = (state_q == ST_RET) && (cnt_q < CNT_W'(2));
  assign stk_hi_o = (state_q == ST_ENTER) ? (cnt_q == push_off + CNT_W'(1))
                                          : ((state_q == ST_RET) && (cnt_q == '0));
  assign gie_o    = gie_q;
  assign vec_o    = vec_q;

  assert_gie_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !gie_o);
  assert_cli_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cli_i |=> !take_o);
  assert_push_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !stk_hi_o) |=> (push_o && stk_hi_o));
  assert_pop_pair_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && stk_hi_o) |=> (pop_o && !stk_hi_o));
  assert_ret_gie_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !push_o && pop_o) |-> !take_o);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int unsigned N_SRC     = 4,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '0,
  parameter int unsigned ENTRY_CYC = 4,
  parameter int unsigned WAKE_CYC  = 4,
  parameter int unsigned RET_CYC   = 4,
  localparam int unsigned VEC_W    = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] wclr_i,
  input  logic             sei_i,
  input  logic             cli_i,
  input  logic             reti_i,
  input  logic             bnd_i,
  input  logic             mcb_i,
  input  logic             sleep_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N_SRC-1:0] clr_o,
  output logic             busy_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             stk_hi_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] pend_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] grant;
  logic [IDX_W-1:0] win_idx;
  logic             any_req;
  logic             eligible;
  logic             take_now;

  irq_flag_bank #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .wclr_i (wclr_i),
    .hwclr_i(clr_o),
    .pend_o (pend_o)
  );

  assign req = pend_o & en_i;

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .req_i  (req),
    .any_o  (any_req),
    .grant_o(grant),
    .idx_o  (win_idx)
  );

  // a request may only cut in where the core is between whole instructions
  assign eligible = (bnd_i && !mcb_i) || sleep_i;
  assign take_now = any_req && gie_o && !cli_i && !busy_o && eligible;
  assign clr_o    = take_now ? (grant & ~LEVEL_MASK) : '0;

  irq_seq_ctrl #(
    .ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC), .RET_CYC(RET_CYC),
    .VEC_W(VEC_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_now_i(take_now),
    .win_idx_i (win_idx),
    .sleep_i   (sleep_i),
    .reti_i    (reti_i),
    .sei_i     (sei_i),
    .cli_i     (cli_i),
    .take_o    (take_o),
    .vec_o     (vec_o),
    .busy_o    (busy_o),
    .push_o    (push_o),
    .pop_o     (pop_o),
    .stk_hi_o  (stk_hi_o),
    .gie_o     (gie_o)
  );

  assert_take_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(gie_o && (|(en_i & pend_o))));
  assert_boundary_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past((bnd_i && !mcb_i) || sleep_i));
  assert_single_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  assert_level_noclr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o & LEVEL_MASK) == '0);
endmodule

// File: tb/irq_sequencer_bench.sv
`timescale 1ns/1ps
module irq_sequencer_bench;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0, en = '0, wclr = '0;
  logic sei = 0, cli = 0, reti = 0, bnd = 0, mcb = 0, slp = 0;
  logic take, busy, push, pop, stk_hi, gie;
  logic [2:0] vec;
  logic [N-1:0] clr, pend;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_sequencer #(.N_SRC(N), .LEVEL_MASK(4'b1000)) u_irq_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .en_i(en), .wclr_i(wclr),
    .sei_i(sei), .cli_i(cli), .reti_i(reti), .bnd_i(bnd), .mcb_i(mcb),
    .sleep_i(slp), .take_o(take), .vec_o(vec), .clr_o(clr), .busy_o(busy),
    .push_o(push), .pop_o(pop), .stk_hi_o(stk_hi), .gie_o(gie), .pend_o(pend)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_src(input logic [N-1:0] m);
    src = m; tick; src = '0;
  endtask

  task automatic do_sei;
    sei = 1; tick; sei = 0;
  endtask

  // called in the first cycle after the deciding edge
  task automatic check_entry(input int v, input bit woke);
    int off = woke ? 4 : 0;
    int len = woke ? 8 : 4;
    chk("R9 take pulse", take, 1);
    chk("R1 vector", vec, v);
    chk("R3 gie cleared on take", gie, 0);
    for (int k = 0; k < len; k++) begin
      chk(woke ? "R10 busy" : "R9 busy", busy, 1);
      chk(woke ? "R10 push" : "R9 push", push, (k == off || k == off + 1) ? 1 : 0);
      if (k == off || k == off + 1) chk("R9 push byte", stk_hi, (k == off + 1) ? 1 : 0);
      if (k > 0) chk("R9 single take", take, 0);
      tick;
    end
    chk(woke ? "R10 idle after" : "R9 idle after", busy, 0);
  endtask

  task automatic check_ret;
    reti = 1; bnd = 1; tick; reti = 0; bnd = 0;
    for (int k = 0; k < 4; k++) begin
      chk("R11 busy", busy, 1);
      chk("R11 pop", pop, (k < 2) ? 1 : 0);
      if (k < 2) chk("R11 pop byte", stk_hi, (k == 0) ? 1 : 0);
      chk("R7 no take in return", take, 0);
      tick;
    end
    chk("R11 idle", busy, 0);
    chk("R11 gie set", gie, 1);
  endtask

  task automatic t_reset;
    chk("R1 reset vec", vec, 0);
    chk("R3 reset gie", gie, 0);
    chk("R9 reset busy", busy, 0);
    chk("R4 reset pend", pend, 0);
    chk("R9 reset take", take, 0);
  endtask

  task automatic t_gate;
    en = '0;
    pulse_src(4'b0001);
    chk("R5 flag kept", pend[0], 1);
    do_sei;
    bnd = 1; #1 chk("R2 disabled src no clear", clr, 0); tick; bnd = 0;
    chk("R2 disabled src no take", take, 0);
    chk("R5 still pending", pend[0], 1);
    cli = 1; tick; cli = 0;
    en = '1;
    bnd = 1; #1 chk("R2 gie off no clear", clr, 0); tick; bnd = 0;
    chk("R2 gie off no take", take, 0);
    sei = 1; bnd = 1; #1 chk("R7 sei cycle no clear", clr, 0); tick; sei = 0; bnd = 0;
    chk("R7 sei cycle no take", take, 0);
    chk("R3 sei sets gie", gie, 1);
    bnd = 1; #1 chk("R4 clear strobe", clr, 4'b0001); tick; bnd = 0;
    chk("R4 flag cleared", pend[0], 0);
    check_entry(1, 0);
  endtask

  task automatic t_ret;
    pulse_src(4'b0010);
    check_ret;
    chk("R7 no take before boundary", take, 0);
    tick;
    chk("R7 still waiting", busy, 0);
    bnd = 1; tick; bnd = 0;
    check_entry(2, 0);
  endtask

  task automatic t_prio;
    wclr = '1; tick; wclr = '0;
    pulse_src(4'b0111);
    do_sei;
    bnd = 1; #1 chk("R13 only winner cleared", clr, 4'b0001); tick; bnd = 0;
    check_entry(1, 0);
    chk("R13 others pending", pend, 4'b0110);
    do_sei;
    bnd = 1; tick; bnd = 0;
    check_entry(2, 0);
    chk("R13 last pending", pend, 4'b0100);
  endtask

  task automatic t_cli;
    do_sei;
    cli = 1; bnd = 1; #1 chk("R8 cli no clear", clr, 0); tick; cli = 0; bnd = 0;
    chk("R8 cli no take", take, 0);
    chk("R8 gie dropped", gie, 0);
    chk("R8 flag kept", pend[2], 1);
  endtask

  task automatic t_mc;
    do_sei;
    bnd = 1; mcb = 1; tick; mcb = 0;
    chk("R12 no take mid instruction", take, 0);
    tick; bnd = 0;
    check_entry(3, 0);
  endtask

  task automatic t_wclr;
    en = '0;
    pulse_src(4'b0001);
    wclr = 4'b0001; tick; wclr = '0;
    chk("R4 write one clears", pend[0], 0);
    src = 4'b0001; wclr = 4'b0001; tick; src = '0; wclr = '0;
    chk("R4 event beats clear", pend[0], 1);
    wclr = '1; tick; wclr = '0;
    chk("R4 all cleared", pend, 0);
  endtask

  task automatic t_level;
    en = 4'b1000;
    src[3] = 1; tick;
    chk("R6 level pending", pend[3], 1);
    src[3] = 0; tick;
    chk("R6 level gone", pend[3], 0);
    do_sei;
    bnd = 1; tick; bnd = 0;
    chk("R6 expired level not served", take, 0);
    src[3] = 1; bnd = 1; #1 chk("R6 no clear strobe", clr, 0); tick; bnd = 0;
    check_entry(4, 0);
    chk("R6 level still live", pend[3], 1);
    src[3] = 0; tick;
  endtask

  task automatic t_sleep;
    en = '1;
    pulse_src(4'b0010);
    do_sei;
    slp = 1; tick; slp = 0;
    check_entry(2, 1);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick; tick; tick;
    rst_n = 1'b1;
    tick;
    t_reset;
    t_gate;
    t_ret;
    t_prio;
    t_cli;
    t_mc;
    t_wclr;
    t_level;
    t_sleep;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule